// File: doc/BRIEF.md
# Channel Context Table Transmit Scanner

The scanner walks a table of per-channel context records held in system memory and looks for channels with frames waiting to go out. Every record takes 32 bytes (16 words). Each record holds a set of scan-control flags, a jump pointer, a 32-bit DLCI, and the base address and current index of that channel's transmit descriptor ring. Record 0 is reserved for the management channel and is never visited. Scanning begins at record 1 when a start pulse arrives.

For a channel marked ready, the scanner reads the current transmit descriptor. If the descriptor's ownership bit gives it to the controller, the scanner raises a transmit request toward the framer. The request carries the channel's DLCI and the 24-bit buffer pointer. The scanner holds the request until the framer reports completion, then moves to the next record. A poll-demand pulse abandons the current walk and restarts it at record 1.

Top module: `ctx_tx_scanner`

## Requirements
- R1: After reset the block issues neither memory reads nor transmit requests until a start pulse arrives.
- R2: The start pulse begins the walk at record 1. Record i is read at byte address B + 32*i, where B is {upper 8-bit base field, low 16-bit base with bit 0 forced to zero}. Record 0 is never read.
- R3: A memory read holds `mem_req` high with a stable, even `mem_addr` until `mem_valid` returns. The data is taken in the cycle `mem_valid` is high.
- R4: Record word 0 holds the flags: bit 0 is transmit-ready, bit 1 is index-enable, bit 2 is end-of-table. The low byte of word 1 is the jump pointer. For a record whose ready bit is clear, only words 0 and 1 are read.
- R5: For a ready record, words 0 to 7 are read in order. The descriptor address is ring + 8*index, where ring = {word 6 bits 7:0, word 5} and index = word 7 bits 7:0. Descriptor word 0 is read, then word 1.
- R6: When bit 15 of descriptor word 1 is set, `tx_req` rises with `tx_dlci` = {word 3, word 4} (byte offsets 6 and 8) and `tx_buf` = {descriptor word 1 bits 7:0, descriptor word 0}. When bit 15 is clear, no request is made and the walk moves on.
- R7: `tx_req` stays high with stable DLCI and buffer outputs until `tx_done`. It drops in the cycle after `tx_done`. No memory read occurs while it is high.
- R8: The next record is chosen as follows. If index-enable is set, the next record is the jump pointer, with a pointer of 0 treated as 1; this takes priority over end-of-table. Otherwise, if end-of-table is set, the walk wraps to 1. Otherwise it goes to index + 1, where an 8-bit wrap to 0 becomes 1.
- R9: A poll-demand pulse outside transmit wait restarts the walk at record 1 in the next cycle and drops any read in flight. During transmit wait the poll is held and takes effect once `tx_done` arrives.
- R10: A start pulse while the walk is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_lo | input | 16 | Table base address, low half (bit 0 ignored) |
| cfg_base_hi | input | 8 | Table base address, upper byte |
| scan_start | input | 1 | Start pulse, acts only when idle |
| poll_demand | input | 1 | Restart-the-walk pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Byte address of the word being read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| tx_req | output | 1 | Transmit request to framer |
| tx_dlci | output | 32 | DLCI for the frame |
| tx_buf | output | 24 | Buffer pointer for the frame |
| tx_done | input | 1 | Framer finished with the request |

## Verification
Some properties are checked by assertions on every cycle:
- the read handshake holds its address and keeps it even;
- the transmit request holds its payload until `tx_done` and then drops;
- idle stays silent;
- record 0 is never read;
- a poll outside transmit wait puts the record-1 address on the bus in the next cycle.

The walk order itself can only be shown by the bench scenarios. These cover the skip of non-ready records, the descriptor address, ownership gating, the priority of jump over end-of-table, a zero pointer, the 8-bit index wrap, a deferred poll, and a start pulse ignored while busy. The bench compares these against an independent behavioural walk of the memory image.

// File: rtl/ctx_tx_scanner.sv
module ctx_tx_scanner #(
  parameter int IDXW       = 8,
  parameter int CURW       = 8,
  parameter int ENT_SHIFT  = 5,
  parameter int DESC_SHIFT = 3,
  parameter int OWN_BIT    = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_base_lo,
  input  logic [7:0]  cfg_base_hi,
  input  logic        scan_start,
  input  logic        poll_demand,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_valid,
  input  logic [15:0] mem_rdata,
  output logic        tx_req,
  output logic [31:0] tx_dlci,
  output logic [23:0] tx_buf,
  input  logic        tx_done
);
  typedef enum logic [2:0] {S_IDLE, S_ENT, S_DESC, S_TX, S_NEXT} state_t;

  localparam logic [IDXW-1:0] FIRST_IDX = IDXW'(1);
  localparam logic [2:0]      LAST_WORD = 3'd7;
  localparam int F_READY = 0;
  localparam int F_INDEX = 1;
  localparam int F_END   = 2;

  state_t          st;
  logic [IDXW-1:0] idx, ptr, nxt_raw, nxt_idx;
  logic [2:0]      wsel, flags;
  logic [15:0]     dlci_hi, dlci_lo, buf_lo;
  logic [7:0]      buf_hi;
  logic [23:0]     ring, base_addr, ent_addr, desc_addr;
  logic [CURW-1:0] cur;
  logic            poll_pend, take, unused_bit;

  assign unused_bit = cfg_base_lo[0];
  assign base_addr  = {cfg_base_hi, cfg_base_lo[15:1], 1'b0};
  assign ent_addr   = base_addr + (24'(idx) << ENT_SHIFT) + {20'd0, wsel, 1'b0};
  assign desc_addr  = ring + (24'(cur) << DESC_SHIFT) + {22'd0, wsel[0], 1'b0};

  assign mem_req  = (st == S_ENT) || (st == S_DESC);
  assign mem_addr = (st == S_DESC) ? desc_addr : ent_addr;
  assign take     = mem_req && mem_valid && !poll_demand;
  assign tx_req   = (st == S_TX);
  assign tx_dlci  = {dlci_hi, dlci_lo};
  assign tx_buf   = {buf_hi, buf_lo};

  assign nxt_raw = flags[F_INDEX] ? ptr : (flags[F_END] ? FIRST_IDX : idx + FIRST_IDX);
  assign nxt_idx = (nxt_raw == '0) ? FIRST_IDX : nxt_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= FIRST_IDX;
      wsel      <= '0;
      flags     <= '0;
      ptr       <= '0;
      dlci_hi   <= '0;
      dlci_lo   <= '0;
      buf_lo    <= '0;
      buf_hi    <= '0;
      ring      <= '0;
      cur       <= '0;
      poll_pend <= 1'b0;
    end else if (poll_demand && st != S_IDLE && st != S_TX) begin
      st        <= S_ENT;
      idx       <= FIRST_IDX;
      wsel      <= '0;
      poll_pend <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (scan_start) begin
          st   <= S_ENT;
          idx  <= FIRST_IDX;
          wsel <= '0;
        end
        S_ENT: if (take) begin
          case (wsel)
            3'd0: flags   <= mem_rdata[2:0];
            3'd1: ptr     <= mem_rdata[IDXW-1:0];
            3'd3: dlci_hi <= mem_rdata;
            3'd4: dlci_lo <= mem_rdata;
            3'd5: ring[15:0]  <= mem_rdata;
            3'd6: ring[23:16] <= mem_rdata[7:0];
            3'd7: cur     <= mem_rdata[CURW-1:0];
            default: ;
          endcase
          if (wsel == 3'd1 && !flags[F_READY]) st <= S_NEXT;
          else if (wsel == LAST_WORD) begin
            st   <= S_DESC;
            wsel <= '0;
          end else wsel <= wsel + 3'd1;
        end
        S_DESC: if (take) begin
          if (!wsel[0]) begin
            buf_lo <= mem_rdata;
            wsel   <= 3'd1;
          end else if (mem_rdata[OWN_BIT]) begin
            buf_hi <= mem_rdata[7:0];
            st     <= S_TX;
          end else st <= S_NEXT;
        end
        S_TX: begin
          if (poll_demand) poll_pend <= 1'b1;
          if (tx_done) st <= S_NEXT;
        end
        S_NEXT: begin
          idx       <= poll_pend ? FIRST_IDX : nxt_idx;
          poll_pend <= 1'b0;
          wsel      <= '0;
          st        <= S_ENT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !scan_start) |=> (!mem_req && !tx_req));

  assert_skip_entry0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENT) |-> (idx != '0));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid && !poll_demand) |=> (mem_req && $stable(mem_addr)));

  assert_addr_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done) |=> (tx_req && $stable(tx_dlci) && $stable(tx_buf)));

  assert_tx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_done) |=> !tx_req);

  assert_poll_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_demand && mem_req) |=> (mem_req && mem_addr == base_addr + (24'd1 << ENT_SHIFT)));
endmodule

// File: tb/ctx_tx_scanner_bench.sv
`timescale 1ns/1ps
module ctx_tx_scanner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base_lo = 16'h0;
  logic [7:0]  cfg_base_hi = 8'h0;
  logic        scan_start = 1'b0, poll_demand = 1'b0;
  logic        mem_req, mem_valid = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata = 16'h0;
  logic        tx_req, tx_done = 1'b0;
  logic [31:0] tx_dlci;
  logic [23:0] tx_buf;

  always #4 clk = ~clk;

  ctx_tx_scanner u_ctx_tx_scanner (
    .clk(clk), .rst_n(rst_n), .cfg_base_lo(cfg_base_lo), .cfg_base_hi(cfg_base_hi),
    .scan_start(scan_start), .poll_demand(poll_demand),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .tx_req(tx_req), .tx_dlci(tx_dlci), .tx_buf(tx_buf), .tx_done(tx_done));

  typedef struct { bit is_tx; logic [31:0] a; logic [23:0] b; } ev_t;

  logic [15:0] mem [0:4095];
  ev_t q[$];
  int n_chk = 0, n_fail = 0, ntx = 0, w_idx = 1, lat = 0, nlat = 0, tx_cnt = 0;
  int poll_mode = 0;
  bit start_req = 0, running = 0, tx_busy = 0, poll_after = 0, drop_chk = 0;
  logic [31:0] held_dlci;

  function automatic logic [15:0] rd(input logic [23:0] a);
    return mem[a[12:1]];
  endfunction
  function automatic logic [23:0] beff();
    return {cfg_base_hi, cfg_base_lo[15:1], 1'b0};
  endfunction
  task automatic wr(input logic [23:0] a, input logic [15:0] d);
    mem[a[12:1]] = d;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_entry(input int i, input logic [15:0] f, input logic [15:0] p,
                           input logic [15:0] dh, input logic [15:0] dl,
                           input logic [23:0] ring, input logic [7:0] cur);
    logic [23:0] e;
    e = beff() + 24'(i * 32);
    wr(e, f); wr(e + 24'd2, p); wr(e + 24'd6, dh); wr(e + 24'd8, dl);
    wr(e + 24'd10, ring[15:0]); wr(e + 24'd12, {8'h00, ring[23:16]}); wr(e + 24'd14, {8'h00, cur});
  endtask

  task automatic set_desc(input logic [23:0] ring, input logic [7:0] cur, input bit own, input logic [23:0] bp);
    logic [23:0] d;
    d = ring + 24'(int'(cur) * 8);
    wr(d, bp[15:0]);
    wr(d + 24'd2, {own, 7'h00, bp[23:16]});
  endtask

  task automatic push_rd(input logic [23:0] a);
    ev_t ev;
    ev.is_tx = 0; ev.a = {8'h00, a}; ev.b = '0;
    q.push_back(ev);
  endtask

  // behavioural walk of one record of the memory image
  task automatic walk_more();
    logic [23:0] e, ring, d;
    logic [15:0] f, p, lo, hi;
    ev_t ev;
    int n;
    e = beff() + 24'(w_idx * 32);
    f = rd(e); p = rd(e + 24'd2);
    push_rd(e); push_rd(e + 24'd2);
    if (f[0]) begin
      for (int k = 2; k < 8; k++) push_rd(e + 24'(2 * k));
      lo = rd(e + 24'd10); hi = rd(e + 24'd12);
      ring = {hi[7:0], lo};
      hi = rd(e + 24'd14);
      d = ring + 24'(int'(hi[7:0]) * 8);
      push_rd(d); push_rd(d + 24'd2);
      hi = rd(d + 24'd2);
      if (hi[15]) begin
        ev.is_tx = 1;
        ev.a = {rd(e + 24'd6), rd(e + 24'd8)};
        ev.b = {hi[7:0], rd(d)};
        q.push_back(ev);
      end
    end
    if (f[1]) n = int'(p[7:0]);
    else if (f[2]) n = 1;
    else n = (w_idx + 1) % 256;
    if (n == 0) n = 1;
    w_idx = n;
  endtask

  task automatic fill();
    while (q.size() < 40) walk_more();
  endtask
  task automatic restart();
    q.delete();
    w_idx = 1;
    fill();
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 0; poll_demand = 0; scan_start = 0; tx_done = 0;
      q.delete(); running = 0; tx_busy = 0; poll_after = 0; lat = 0; drop_chk = 0;
    end else begin
      ev_t ev;
      poll_demand = 0; scan_start = 0; tx_done = 0;
      if (drop_chk) begin
        chk(!tx_req, "R7 drop after done", {31'd0, tx_req}, 32'd0);
        drop_chk = 0;
      end
      if (tx_busy) begin
        chk(tx_req && tx_dlci == held_dlci, "R7 hold", tx_dlci, held_dlci);
        if (tx_cnt == 0) begin
          tx_done = 1; tx_busy = 0; drop_chk = 1;
          if (poll_after) begin poll_after = 0; restart(); end
        end else tx_cnt--;
      end else if (tx_req) begin
        fill();
        ev = q.pop_front();
        chk(ev.is_tx && tx_dlci == ev.a, "R6 R8 dlci", tx_dlci, ev.a);
        chk(ev.is_tx && tx_buf == ev.b, "R6 R8 buffer", {8'h0, tx_buf}, {8'h0, ev.b});
        chk(!mem_req, "R7 no read during tx", {31'd0, mem_req}, 32'd0);
        held_dlci = tx_dlci;
        tx_busy = 1; tx_cnt = 1 + (ntx % 3); ntx++;
      end
      if (start_req) begin
        scan_start = 1; start_req = 0;
        if (!running) begin running = 1; restart(); end
      end
      if (mem_valid) mem_valid = 0;
      else if (poll_mode == 1 && running && !tx_busy && mem_req) begin
        poll_demand = 1; poll_mode = 0; lat = 0; restart();
      end else if (poll_mode == 2 && tx_busy && tx_cnt > 0) begin
        poll_demand = 1; poll_mode = 0; poll_after = 1;
      end else if (mem_req) begin
        if (!running) chk(0, "R1 read before start", 32'd1, 32'd0);
        else if (lat == 0) begin
          fill();
          ev = q.pop_front();
          chk(!ev.is_tx && mem_addr == ev.a[23:0], "R2 R3 R4 R5 R8 R9 R10 read address",
              {8'h0, mem_addr}, ev.a);
          mem_rdata = rd(mem_addr);
          mem_valid = 1;
          lat = nlat % 3; nlat++;
        end else lat--;
      end
    end
  end

  task automatic wait_tx(input int n);
    while (ntx < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ntx, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    // table A: odd low base, bit 0 must be dropped
    cfg_base_hi = 8'h00; cfg_base_lo = 16'h0401;
    set_entry(0, 16'h0007, 16'h0003, 16'hDEAD, 16'hBEEF, 24'h001500, 8'd0);
    set_desc(24'h001500, 8'd0, 1, 24'h999999);
    set_entry(1, 16'h0001, 16'h0000, 16'h0010, 16'h0A01, 24'h001000, 8'd2);
    set_desc(24'h001000, 8'd2, 1, 24'hAB1234);
    set_entry(2, 16'h0000, 16'h0005, 16'h0020, 16'h0A02, 24'h001600, 8'd0);
    set_entry(3, 16'h0001, 16'h0000, 16'h0030, 16'h0A03, 24'h001100, 8'd0);
    set_desc(24'h001100, 8'd0, 0, 24'h333333);
    set_entry(4, 16'h0007, 16'h0006, 16'h0040, 16'h0A04, 24'h001200, 8'd1);
    set_desc(24'h001200, 8'd1, 1, 24'h5500AA);
    set_entry(5, 16'h0001, 16'h0000, 16'h0050, 16'h0A05, 24'h001300, 8'd0);
    set_desc(24'h001300, 8'd0, 1, 24'h555555);
    set_entry(6, 16'h0005, 16'h0000, 16'h0060, 16'h0A06, 24'h001400, 8'd255);
    set_desc(24'h001400, 8'd255, 1, 24'h0F0F0F);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!mem_req && !tx_req, "R1 idle after reset", {30'd0, mem_req, tx_req}, 32'd0);
    end
    start_req = 1;
    wait_tx(3);
    poll_mode = 1;
    wait_tx(5);
    start_req = 1;
    wait_tx(6);
    poll_mode = 2;
    wait_tx(10);
    // table B: upper base byte, jump, 8-bit index wrap
    @(negedge clk); rst_n = 0;
    cfg_base_hi = 8'h12; cfg_base_lo = 16'h0800;
    set_entry(1, 16'h0001, 16'h0000, 16'h1111, 16'h0B01, 24'h121800, 8'd3);
    set_desc(24'h121800, 8'd3, 1, 24'h777777);
    set_entry(2, 16'h0002, 16'h00FE, 16'h2222, 16'h0B02, 24'h000000, 8'd0);
    set_entry(254, 16'h0000, 16'h0000, 16'h3333, 16'h0BFE, 24'h000000, 8'd0);
    set_entry(255, 16'h0001, 16'h0000, 16'h4444, 16'h0BFF, 24'h121900, 8'd4);
    set_desc(24'h121900, 8'd4, 1, 24'h010203);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    start_req = 1;
    wait_tx(ntx + 6);
    // table C: zero jump pointer maps to record 1
    @(negedge clk); rst_n = 0;
    set_entry(2, 16'h0002, 16'h0000, 16'h2222, 16'h0B02, 24'h000000, 8'd0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    start_req = 1;
    wait_tx(ntx + 4);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule